// File: doc/BRIEF.md
# Dual-Source Prescaled Interval Timer

This block is an 8-bit up-counting timer whose count source is chosen by a 4-bit select field in a small mode register. With the top select bit clear, the counter advances on one of eight taps of a free-running prescaler on the system clock, which gives an interval timer. With the top two select bits at `10`, the counter advances on one of four taps of a second prescaler. That prescaler is stepped by a 32.768 kHz tick-enable input, so the counter overflows at fixed real-time periods of 1 s, 0.5 s, 0.25 s or 31.25 ms. With the top two select bits at `11`, both the crystal-side prescaler and the counter are held at zero.

Everything runs on the single system clock. Each prescaler tap becomes a one-cycle count enable, and no derived clock is used. Software writes and reads back the mode register and reads the counter, which it cannot write. Every wrap of the counter from 0xFF to 0x00 raises an interrupt request flag. The flag stays set until a clear strobe removes it.

Top module: `dst_timer_top`

## Requirements
- R1: After reset the mode register reads 0x10 (select field 0000, bit 4 set, bits 7:5 zero), the counter reads 0 and the interrupt flag is 0.
- R2: Select codes 0 to 7 make the counter advance once every 8192, 4096, 2048, 512, 256, 128, 32 and 8 system clock cycles. The system prescaler runs freely from reset, so with the reset code the first increment comes exactly 8192 cycles after reset is released.
- R3: Select codes 8, 9, 10 and 11 make the counter advance once every 128, 64, 32 and 4 pulses of the tick-enable input. With no tick pulses the counter does not move.
- R4: While select bits 3:2 are 11 (codes 12 to 15), the counter and the crystal-side prescaler are held at 0. After leaving code 12 for code 11, the first increment therefore needs a full 4 tick pulses.
- R5: The counter only counts up by one per selected tick. Writes to the mode register do not load it.
- R6: An advance of the counter from 0xFF wraps it to 0x00 and sets the interrupt flag to 1.
- R7: The interrupt flag stays at 1 until the clear strobe is applied. If an overflow and a clear strobe fall in the same cycle, the flag ends at 1.
- R8: Bits 3:0 of the mode register hold the written select code. Bit 4 always reads 1 and bits 7:5 always read 0, whatever value is written.
- R9: Changing the select code leaves the counter value unchanged. Counting resumes from that value on the next tick of the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wtick_i | input | 1 | 32.768 kHz tick enable, one cycle wide per tick |
| reg_wr_i | input | 1 | Mode register write strobe |
| reg_wdata_i | input | 8 | Mode register write data |
| reg_rdata_o | output | 8 | Mode register readback |
| irq_clr_i | input | 1 | Interrupt flag clear strobe |
| cnt_o | output | 8 | Counter value (read-only) |
| irq_o | output | 1 | Interrupt request flag |

## Verification
On every cycle the assertions check the following: the counter holds or steps by exactly one depending on the selected tick, the hold codes force the counter and the crystal prescaler to zero, a wrap sets the flag, the flag stays set without a clear, and the register captures written select codes. The bench's scenarios are the only place the per-code divide ratios are shown, by measuring the spacing between increments. The same holds for the exact 8192-cycle first increment after reset, the same-cycle set-over-clear collision reached by stepping the tick input by hand, and counter preservation across a change of select code.

// File: rtl/dst_pkg.sv
`timescale 1ns/1ps
package dst_pkg;

    localparam int CNT_W     = 8;
    localparam int SEL_W     = 4;
    localparam int SYS_TAPS  = 8;
    localparam int WCH_TAPS  = 4;

    typedef enum logic [1:0] {
        SRC_SYS   = 2'd0,
        SRC_WATCH = 2'd1,
        SRC_HOLD  = 2'd2
    } src_e;

    typedef struct packed {
        logic [2:0]       zero;
        logic             one;
        logic [SEL_W-1:0] sel;
    } mode_rd_t;

    // number of low prescaler bits that must all be ones for a system tap
    function automatic int sys_tap_bits(input int idx);
        case (idx)
            0:       return 13;
            1:       return 12;
            2:       return 11;
            3:       return 9;
            4:       return 8;
            5:       return 7;
            6:       return 5;
            default: return 3;
        endcase
    endfunction

    // same for the crystal-side taps
    function automatic int wch_tap_bits(input int idx);
        case (idx)
            0:       return 7;
            1:       return 6;
            2:       return 5;
            default: return 2;
        endcase
    endfunction

    function automatic src_e decode_src(input logic [SEL_W-1:0] sel);
        if (!sel[3])           return SRC_SYS;
        else if (!sel[2])      return SRC_WATCH;
        else                   return SRC_HOLD;
    endfunction

endpackage

// File: rtl/dst_sys_prescaler.sv
`timescale 1ns/1ps
module dst_sys_prescaler #(
    parameter int W    = 13,
    parameter int NTAP = dst_pkg::SYS_TAPS
) (
    input  logic            clk,
    input  logic            rst,
    output logic [NTAP-1:0] tap_o
);
    logic [W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        localparam int B = dst_pkg::sys_tap_bits(i);
        assign tap_o[i] = &pre_q[B-1:0];
    end

    // R2: free-running divider
    a_r2_free_run: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pre_q == $past(pre_q) + 1'b1);
endmodule

// File: rtl/dst_watch_prescaler.sv
`timescale 1ns/1ps
module dst_watch_prescaler #(
    parameter int W    = 7,
    parameter int NTAP = dst_pkg::WCH_TAPS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic            clr_i,
    output logic [NTAP-1:0] tap_o
);
    logic [W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) pre_q <= '0;
        else if (en_i)    pre_q <= pre_q + 1'b1;
    end

    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        localparam int B = dst_pkg::wch_tap_bits(i);
        assign tap_o[i] = en_i & (&pre_q[B-1:0]);
    end

    // R4: hold code clears the crystal-side prescaler
    a_r4_wclr: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> pre_q == '0);
    // R3: no tick pulse, no movement
    a_r3_idle: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/dst_count_core.sv
`timescale 1ns/1ps
module dst_count_core #(
    parameter int CW = dst_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          hold_i,
    input  logic          irq_clr_i,
    output logic [CW-1:0] cnt_o,
    output logic          irq_o
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;
    logic          irq_q;
    logic          wrap;

    assign wrap = tick_i & ~hold_i & (cnt_q == CMAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (hold_i)      cnt_q <= '0;
            else if (tick_i) cnt_q <= cnt_q + 1'b1;
            if (wrap)           irq_q <= 1'b1;
            else if (irq_clr_i) irq_q <= 1'b0;
        end
    end

    assign cnt_o = cnt_q;
    assign irq_o = irq_q;

    // R5: single-step up counting
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !hold_i) |=> cnt_q == $past(cnt_q) + 1'b1);
    a_r5_still: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !hold_i) |=> $stable(cnt_q));
    // R4: hold clears the counter
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> cnt_q == '0);
    // R6: wrap raises the flag
    a_r6_wrap_sets: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !hold_i && cnt_q == CMAX) |=> (irq_q && cnt_q == '0));
    // R7: flag is sticky without a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !irq_clr_i) |=> irq_q);
endmodule

// File: rtl/dst_timer_top.sv
`timescale 1ns/1ps
module dst_timer_top #(
    parameter int SYS_W = 13,
    parameter int WCH_W = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wtick_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic       irq_clr_i,
    output logic [7:0] cnt_o,
    output logic       irq_o
);
    import dst_pkg::*;

    logic [SEL_W-1:0]    sel_q;
    logic [SYS_TAPS-1:0] sys_tap;
    logic [WCH_TAPS-1:0] wch_tap;
    src_e                src;
    logic                tick;
    logic                hold;
    mode_rd_t            rd;
    logic                unused_wbits;

    assign unused_wbits = ^reg_wdata_i[7:SEL_W];

    always_ff @(posedge clk) begin
        if (rst)           sel_q <= '0;
        else if (reg_wr_i) sel_q <= reg_wdata_i[SEL_W-1:0];
    end

    assign src  = decode_src(sel_q);
    assign hold = (src == SRC_HOLD);

    always_comb begin
        case (src)
            SRC_SYS:   tick = sys_tap[sel_q[2:0]];
            SRC_WATCH: tick = wch_tap[sel_q[1:0]];
            default:   tick = 1'b0;
        endcase
    end

    always_comb begin
        rd.zero = '0;
        rd.one  = 1'b1;
        rd.sel  = sel_q;
    end
    assign reg_rdata_o = rd;

    dst_sys_prescaler #(.W(SYS_W), .NTAP(SYS_TAPS)) u_sys (
        .clk   (clk),
        .rst   (rst),
        .tap_o (sys_tap)
    );

    dst_watch_prescaler #(.W(WCH_W), .NTAP(WCH_TAPS)) u_wch (
        .clk   (clk),
        .rst   (rst),
        .en_i  (wtick_i),
        .clr_i (hold),
        .tap_o (wch_tap)
    );

    dst_count_core #(.CW(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .hold_i    (hold),
        .irq_clr_i (irq_clr_i),
        .cnt_o     (cnt_o),
        .irq_o     (irq_o)
    );

    // R8: written select lands in the register
    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        reg_wr_i |=> reg_rdata_o[3:0] == $past(reg_wdata_i[3:0]));
    a_r8_fixed: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (reg_rdata_o[7:4] == 4'b0001));
    // R3: crystal codes only advance on a tick pulse
    a_r3_gated: assert property (@(posedge clk) disable iff (rst)
        (sel_q[3:2] == 2'b10 && !wtick_i) |=> $stable(cnt_o));
endmodule

// File: tb/test_dst_timer_top.sv
`timescale 1ns/1ps
module test_dst_timer_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wtick_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       irq_clr_i = 1'b0;
    logic [7:0] cnt_o;
    logic       irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    localparam int NV = 12;
    localparam int VEC_PER [NV] = '{8192, 4096, 2048, 512, 256, 128, 32, 8,
                                    128, 64, 32, 4};

    always #4 clk = ~clk;

    dst_timer_top i_dst_timer_top (
        .clk         (clk),
        .rst         (rst),
        .wtick_i     (wtick_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_clr_i   (irq_clr_i),
        .cnt_o       (cnt_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d (0x%0h), expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wr_mode(input logic [7:0] d);
        @(negedge clk);
        reg_wr_i    = 1'b1;
        reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i    = 1'b0;
    endtask

    // negedges until the counter changes (capped)
    task automatic gap(output int n);
        logic [7:0] prev;
        prev = cnt_o;
        n = 0;
        while (cnt_o == prev && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wpulse(input int k);
        for (int p = 0; p < k; p++) begin
            @(negedge clk); wtick_i = 1'b1;
            @(negedge clk); wtick_i = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got %0d, expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        logic [7:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(reg_rdata_o == 8'h10, "R1 mode readback", reg_rdata_o, 8'h10);
        chk(cnt_o == 8'h00, "R1 counter", cnt_o, 0);
        chk(irq_o == 1'b0, "R1 flag", irq_o, 0);

        // R2 first increment exactly 8192 cycles after reset
        gap(n);
        chk(n == 8192, "R2 first increment after reset", n, 8192);

        // vector table: R2 (codes 0-7) and R3 (codes 8-11)
        wtick_i = 1'b1;
        for (int i = 0; i < NV; i++) begin
            wr_mode(8'(i));
            gap(n);
            gap(n);
            chk(n == VEC_PER[i], (i < 8) ? "R2 system divide" : "R3 crystal divide",
                n, VEC_PER[i]);
        end

        // R4 hold codes
        wr_mode(8'h0C);
        repeat (3) @(negedge clk);
        chk(cnt_o == 0, "R4 hold code 12 clears counter", cnt_o, 0);
        wr_mode(8'h0F);
        repeat (50) @(negedge clk);
        chk(cnt_o == 0, "R4 hold code 15 keeps counter", cnt_o, 0);
        wr_mode(8'h0C);
        @(negedge clk); reg_wr_i = 1'b1; reg_wdata_i = 8'h0B;
        @(negedge clk); reg_wr_i = 1'b0;
        gap(n);
        chk(n == 4, "R4 crystal prescaler restarted from zero", n, 4);

        // R3 no tick pulses, no movement
        wtick_i = 1'b0;
        @(negedge clk);
        v = cnt_o;
        repeat (100) @(negedge clk);
        chk(cnt_o == v, "R3 counter idle without tick", cnt_o, v);

        // R5 / R8 write with junk upper bits, counter untouched
        wr_mode(8'hEB);
        chk(reg_rdata_o == 8'h1B, "R8 readback of 0xEB", reg_rdata_o, 8'h1B);
        chk(cnt_o == v, "R5 register write does not load counter", cnt_o, v);
        wr_mode(8'h00);
        chk(reg_rdata_o == 8'h10, "R8 bit4 stays set on zero write", reg_rdata_o, 8'h10);

        // R5/R6/R7 overflow with set-over-clear collision
        wr_mode(8'h0C);
        wr_mode(8'h0B);
        wpulse(1020);
        chk(cnt_o == 8'hFF, "R5 1020 pulses give 255", cnt_o, 255);
        chk(irq_o == 1'b0, "R6 no flag before wrap", irq_o, 0);
        wpulse(3);
        @(negedge clk); wtick_i = 1'b1; irq_clr_i = 1'b1;
        @(negedge clk); wtick_i = 1'b0; irq_clr_i = 1'b0;
        chk(cnt_o == 8'h00, "R6 wrap to zero", cnt_o, 0);
        chk(irq_o == 1'b1, "R7 set wins over clear", irq_o, 1);
        repeat (20) @(negedge clk);
        chk(irq_o == 1'b1, "R7 flag sticky", irq_o, 1);
        @(negedge clk); irq_clr_i = 1'b1;
        @(negedge clk); irq_clr_i = 1'b0;
        chk(irq_o == 1'b0, "R7 clear strobe", irq_o, 0);

        // R9 select change keeps counter
        wpulse(8);
        chk(cnt_o == 8'h02, "R9 setup value", cnt_o, 2);
        wr_mode(8'h0A);
        chk(cnt_o == 8'h02, "R9 after switch to code 10", cnt_o, 2);
        wr_mode(8'h07);
        chk(cnt_o == 8'h02, "R9 after switch to code 7", cnt_o, 2);
        gap(n);
        chk(cnt_o == 8'h03, "R9 resumes from held value", cnt_o, 3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule